// File: doc/BRIEF.md
# Timer Output Compare Unit

This block pairs an up-counting timer register with one compare channel. On every timer tick, the comparator checks the counter value against the active compare value. A hit raises a sticky match flag, which serves as the interrupt request. It also drives a waveform output pin according to a compare-output mode and a waveform generation mode. A CPU can write the compare value and the counter, pulse a force strobe and clear the flag. The timer advances only when the tick input is high, so the prescaler is left outside the block.

There are two non-PWM modes: free-running and clear-on-match. In these modes a compare write takes effect on the next clock, and the force strobe acts like a match on the pin. There are two PWM modes. In these, compare writes land in a holding register. The holding register moves into the active compare value only at one fixed point of the count cycle: the wrap to zero in one mode and the arrival at the maximum count in the other. This keeps every PWM period whole. Any CPU write to the counter suppresses the match on the next tick, however many idle clocks pass before that tick. All pins are plain control or status pins; there is no streaming interface, so no back-pressure rules apply.

Top module: `tmr_oc_unit`

## Requirements
- R1: After reset, the count output, the active compare value, the pin and the flag are all 0, and the holding register is 0.
- R2: When tick is high and there is no counter write, the counter advances by one, going from 255 to 0. When tick is low, it holds. A counter write loads the written value on the next clock.
- R3: A tick with count equal to the active compare value, and not blocked, is a match. A match sets the flag on the next clock. The flag stays set until flag_clr is pulsed. If a match and flag_clr occur together, the match wins.
- R4: wgm_mode=2 (clear-on-match) loads the counter with 0 on a match tick instead of incrementing it.
- R5: In wgm_mode 0 or 2, com_mode selects what a match does to the pin on the next clock: 1 toggles it, 2 clears it, 3 sets it. com_mode=0 holds the pin at 0 in every wgm_mode.
- R6: In wgm_mode 0 or 2, a force_cmp pulse changes the pin exactly as a match would. It does not set the flag and it does not change the counter.
- R7: In wgm_mode 1 or 3 (PWM), force_cmp has no effect on the pin or the flag.
- R8: A counter write blocks a match on its own cycle and on the next tick after it, even if that tick comes many idle clocks later.
- R9: In wgm_mode 0 or 2, a compare write appears on cmp_value on the next clock.
- R10: In PWM modes, a compare write goes to the holding register. The holding register is copied into cmp_value on a tick at count 255 when wgm_mode=1, and on a tick at count 254 when wgm_mode=3. At any other time cmp_value holds.
- R11: In PWM modes, com_mode=2 sets the pin on a tick at count 255 and clears it on a match. com_mode=3 does the reverse. The count-255 event takes priority over a match. com_mode=1 holds the pin at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| wgm_mode | input | 2 | Waveform generation mode: 0 free-run, 1 PWM loading at wrap, 2 clear-on-match, 3 PWM loading at top |
| com_mode | input | 2 | Compare-output mode: 0 off, 1 toggle, 2 clear/non-inverting, 3 set/inverting |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| force_cmp | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| count | output | 8 | Current counter value |
| cmp_value | output | 8 | Active compare value |
| oc_pin | output | 1 | Waveform output |
| match_flag | output | 1 | Sticky match flag (interrupt request) |

## Verification
The comparator is exercised in three ways. First, a plain count-up into the compare value checks that the flag and the pin move on the cycle after the matching tick. Second, counter writes land exactly on the compare value, both with idle clocks before the next tick and one step short of it; this separates a block that lasts one clock from one that lasts until the next tick. Third, the clear-on-match mode shows whether a match reloads the counter. The PWM cases place count 254 and 255 next to a pending holding-register value, which shows whether the load point follows the mode. Force pulses are sent both alone and together with a tick, which shows whether forcing leaves the flag and the counter alone.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;
  typedef enum logic [1:0] {
    WG_FREE    = 2'd0,
    WG_PWM_BOT = 2'd1,
    WG_CLRMAT  = 2'd2,
    WG_PWM_TOP = 2'd3
  } wg_mode_t;

  typedef enum logic [1:0] {
    CO_OFF    = 2'd0,
    CO_TOGGLE = 2'd1,
    CO_CLEAR  = 2'd2,
    CO_SET    = 2'd3
  } co_mode_t;
endpackage

// File: rtl/tmr_oc_counter.sv
module tmr_oc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr_zero,
  output logic [W-1:0] cnt,
  output logic         blk
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else begin
      if (wr_en) cnt <= wr_data;
      else if (tick) cnt <= clr_zero ? '0 : cnt + 1'b1;
      if (wr_en) blk <= 1'b1;
      else if (tick) blk <= 1'b0;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt));
  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && !clr_zero) |=> cnt == W'($past(cnt) + 1'b1));
endmodule

// File: rtl/tmr_oc_compare.sv
module tmr_oc_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm,
  input  logic         upd,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  input  logic         blk,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] ocr,
  output logic         match
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      ocr    <= '0;
    end else begin
      if (wr_en) hold_q <= wr_data;
      if (pwm) begin
        if (upd) ocr <= hold_q;
      end else if (wr_en) begin
        ocr <= wr_data;
      end
    end
  end

  assign match = tick && !blk && !cnt_wr && (cnt == ocr);

  p_buf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !upd) |=> $stable(ocr));
  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_wr) |-> !match);
endmodule

// File: rtl/tmr_oc_wave.sv
module tmr_oc_wave
  import tmr_oc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwm,
  input  co_mode_t com,
  input  logic     match,
  input  logic     force_hit,
  input  logic     bottom,
  input  logic     flag_clr,
  output logic     pin,
  output logic     flag
);
  logic hit;
  assign hit = match || (force_hit && !pwm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin <= 1'b0;
    end else if (com == CO_OFF) begin
      pin <= 1'b0;
    end else if (pwm) begin
      if (com == CO_TOGGLE) pin <= 1'b0;
      else if (bottom) pin <= (com == CO_CLEAR);
      else if (match) pin <= (com == CO_SET);
    end else if (hit) begin
      case (com)
        CO_TOGGLE: pin <= ~pin;
        CO_CLEAR:  pin <= 1'b0;
        default:   pin <= 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else if (match) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  p_force_noflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hit && !match && !flag) |=> !flag);
  p_pwm_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !bottom && !match && force_hit) |=> $stable(pin) || com == CO_OFF || com == CO_TOGGLE);
endmodule

// File: rtl/tmr_oc_unit.sv
module tmr_oc_unit
  import tmr_oc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   wgm_mode,
  input  logic [1:0]   com_mode,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         force_cmp,
  input  logic         flag_clr,
  output logic [W-1:0] count,
  output logic [W-1:0] cmp_value,
  output logic         oc_pin,
  output logic         match_flag
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] PREV = MAXV - 1'b1;

  wg_mode_t wg;
  co_mode_t co;
  logic pwm, bottom, topev, upd, match, blk, ctc_clr;

  assign wg      = wg_mode_t'(wgm_mode);
  assign co      = co_mode_t'(com_mode);
  assign pwm     = (wg == WG_PWM_BOT) || (wg == WG_PWM_TOP);
  assign bottom  = tick && (count == MAXV);
  assign topev   = tick && (count == PREV);
  assign upd     = (wg == WG_PWM_BOT) ? bottom : topev;
  assign ctc_clr = (wg == WG_CLRMAT) && match;

  tmr_oc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(cnt_we), .wr_data(cnt_wdata), .clr_zero(ctc_clr),
    .cnt(count), .blk(blk)
  );

  tmr_oc_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .pwm(pwm), .upd(upd),
    .wr_en(cmp_we), .wr_data(cmp_wdata), .tick(tick), .blk(blk),
    .cnt_wr(cnt_we), .cnt(count), .ocr(cmp_value), .match(match)
  );

  tmr_oc_wave u_wave (
    .clk(clk), .rst_n(rst_n), .pwm(pwm), .com(co), .match(match),
    .force_hit(force_cmp), .bottom(bottom), .flag_clr(flag_clr),
    .pin(oc_pin), .flag(match_flag)
  );

  p_ctc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wg == WG_CLRMAT) && match) |=> count == '0);
endmodule

// File: tb/tmr_oc_unit_tb.sv
module tmr_oc_unit_tb;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] wgm_mode = 0, com_mode = 0;
  logic cmp_we = 0, cnt_we = 0, force_cmp = 0, flag_clr = 0;
  logic [7:0] cmp_wdata = 0, cnt_wdata = 0;
  logic [7:0] count, cmp_value;
  logic oc_pin, match_flag;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tmr_oc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wgm_mode(wgm_mode), .com_mode(com_mode),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .force_cmp(force_cmp), .flag_clr(flag_clr), .count(count), .cmp_value(cmp_value),
    .oc_pin(oc_pin), .match_flag(match_flag)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [1:0] wg, logic [1:0] co);
    rst_n = 0; wgm_mode = wg; com_mode = co;
    idle(2);
    rst_n = 1;
  endtask

  task automatic ticks(int n);
    tick = 1; idle(n); tick = 0;
  endtask

  task automatic wr_cnt(logic [7:0] v);
    cnt_we = 1; cnt_wdata = v; idle(1); cnt_we = 0;
  endtask

  task automatic wr_cmp(logic [7:0] v);
    cmp_we = 1; cmp_wdata = v; idle(1); cmp_we = 0;
  endtask

  task automatic pulse_force(logic with_tick);
    force_cmp = 1; tick = with_tick; idle(1); force_cmp = 0; tick = 0;
  endtask

  task automatic clr_flag();
    flag_clr = 1; idle(1); flag_clr = 0;
  endtask

  task automatic t_reset();
    do_reset(0, 1);
    chk("R1 count", count, 0);
    chk("R1 cmp", cmp_value, 0);
    chk("R1 pin", oc_pin, 0);
    chk("R1 flag", match_flag, 0);
  endtask

  task automatic t_count();
    do_reset(0, 0);
    wr_cmp(8'hC8);
    ticks(5);
    chk("R2 inc", count, 5);
    idle(3);
    chk("R2 hold", count, 5);
    wr_cnt(8'hFD);
    chk("R2 load", count, 8'hFD);
    ticks(3);
    chk("R2 wrap", count, 0);
  endtask

  task automatic t_match();
    do_reset(0, 1);
    wr_cmp(10);
    wr_cnt(8);
    ticks(2);
    chk("R3 no early flag", match_flag, 0);
    ticks(1);
    chk("R3 flag set", match_flag, 1);
    chk("R5 toggle", oc_pin, 1);
    chk("R3 count past match", count, 11);
    idle(2);
    chk("R3 sticky", match_flag, 1);
    clr_flag();
    chk("R3 cleared", match_flag, 0);
  endtask

  task automatic t_com();
    do_reset(0, 3);
    wr_cmp(3);
    ticks(4);
    chk("R5 set", oc_pin, 1);
    com_mode = 2;
    ticks(256);
    chk("R5 clear", oc_pin, 0);
    com_mode = 3; ticks(256);
    chk("R5 set again", oc_pin, 1);
    com_mode = 0; idle(1);
    chk("R5 off holds 0", oc_pin, 0);
  endtask

  task automatic t_ctc();
    do_reset(2, 1);
    wr_cmp(5);
    ticks(6);
    chk("R4 reload zero", count, 0);
    chk("R4 flag", match_flag, 1);
    ticks(3);
    chk("R4 resume", count, 3);
  endtask

  task automatic t_force();
    do_reset(0, 1);
    wr_cmp(50);
    ticks(3);
    pulse_force(0);
    chk("R6 pin forced", oc_pin, 1);
    chk("R6 no flag", match_flag, 0);
    chk("R6 count kept", count, 3);
    pulse_force(1);
    chk("R6 pin toggled", oc_pin, 0);
    chk("R6 count ticks", count, 4);
    chk("R6 no flag 2", match_flag, 0);
  endtask

  task automatic t_pwm_force();
    do_reset(1, 3);
    pulse_force(0);
    chk("R7 pin ignored", oc_pin, 0);
    chk("R7 flag ignored", match_flag, 0);
  endtask

  task automatic t_block();
    do_reset(0, 1);
    wr_cmp(20);
    wr_cnt(20);
    idle(3);
    ticks(1);
    chk("R8 blocked flag", match_flag, 0);
    chk("R8 blocked pin", oc_pin, 0);
    chk("R8 count", count, 21);
    wr_cnt(19);
    ticks(2);
    chk("R8 unblocked", match_flag, 1);
  endtask

  task automatic t_direct();
    do_reset(0, 0);
    wr_cmp(8'h77);
    chk("R9 direct write", cmp_value, 8'h77);
  endtask

  task automatic t_buf_bot();
    do_reset(1, 0);
    wr_cmp(8'h40);
    chk("R10 held", cmp_value, 0);
    wr_cnt(8'hFD);
    ticks(2);
    chk("R10 not yet", cmp_value, 0);
    ticks(1);
    chk("R10 wrap load", cmp_value, 8'h40);
    chk("R10 count", count, 0);
  endtask

  task automatic t_buf_top();
    do_reset(3, 0);
    wr_cmp(8'h40);
    wr_cnt(8'hFC);
    ticks(2);
    chk("R10 top not yet", cmp_value, 0);
    ticks(1);
    chk("R10 top load", cmp_value, 8'h40);
    chk("R10 top count", count, 8'hFF);
  endtask

  task automatic t_pwm_pin(logic [1:0] co);
    logic lvl;
    lvl = (co == 2);
    do_reset(1, co);
    wr_cmp(8'h10);
    wr_cnt(8'hFF);
    ticks(1);
    chk("R11 bottom", oc_pin, lvl);
    ticks(16);
    chk("R11 before match", oc_pin, lvl);
    ticks(1);
    chk("R11 match", oc_pin, !lvl);
    chk("R11 flag", match_flag, 1);
  endtask

  task automatic t_pwm_off();
    do_reset(1, 1);
    wr_cnt(8'hFF);
    ticks(1);
    chk("R11 mode1 pin low", oc_pin, 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    idle(1);
    t_reset();
    t_count();
    t_match();
    t_com();
    t_ctc();
    t_force();
    t_pwm_force();
    t_block();
    t_direct();
    t_buf_bot();
    t_buf_top();
    t_pwm_pin(2);
    t_pwm_pin(3);
    t_pwm_off();
    summary();
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end
endmodule